// File: doc/BRIEF.md
# Dual-Role SPI Control Port with Buffer Handshake

This block joins a local processor to a host over a four-wire SPI link and carries one byte in each direction at a time. In slave role the host drives chip select, clock and data-in, and the port returns whatever byte the processor has queued. In master role the port generates the clock itself, selects a peer through its own chip-select output and exchanges one byte each time the processor queues one. All pins are sampled in the system clock domain through a synchronizer, so the external clock must be several system clocks slow.

Two active-low handshake lines tell the host when to act. `irq_no` is low while a queued byte is waiting to be shifted out. `busy_no` is low while an incoming byte is waiting for the processor. If another master pulls `cs_ni` low while the port is in master role, the port latches a mode fault and falls back to slave role until the processor clears the fault.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset `irq_no`, `busy_no` and `peer_cs_no` are 1, `mode_fault_o` and `overrun_o` are 0, and all three output enables are 0 while `cs_ni` is high.
- R2: In slave role, with `cs_ni` low, 8 bits on `mosi_i` are taken MSB first, one on each rising edge of `sck_i`. The completed byte appears on `rd_data_o` and `busy_no` goes low.
- R3: A one-cycle `rd_i` pulse while a byte is held returns `busy_no` to 1.
- R4: A byte that completes while `busy_no` is low is discarded. `rd_data_o` keeps the earlier byte and `overrun_o` goes to 1. The next `rd_i` clears `overrun_o`.
- R5: A `wr_i` pulse while no byte is queued stores `wr_data_i` and drives `irq_no` low. A `wr_i` pulse while a byte is already queued is ignored.
- R6: In slave role the queued byte is on `miso_o` MSB first. The first bit is valid before the first rising edge of `sck_i`, and each later bit follows a falling edge. `irq_no` returns to 1 once all 8 bits are out. With nothing queued the port shifts out 0x00.
- R7: When `cs_ni` rises before 8 rising edges, the partial bits are dropped and `busy_no` stays 1. The next full byte is received intact.
- R8: In slave role `sck_oe_o` and `mosi_oe_o` are 0, and `miso_oe_o` is 1 only while `cs_ni` is low. In master role `sck_oe_o` and `mosi_oe_o` are 1 and `miso_oe_o` is 0.
- R9: In master role, a queued byte starts a transfer and drives `peer_cs_no` low. The port then gives 8 `sck_o` pulses, each level lasting HALF_DIV clocks. The byte goes out MSB first on `mosi_o`, and `miso_i` is sampled on each rising edge into the receive buffer. Afterwards `peer_cs_no` and `irq_no` return to 1.
- R10: `cs_ni` low while `master_en_i` is 1 sets `mode_fault_o` and forces slave role: `sck_oe_o` goes to 0 and `peer_cs_no` to 1. The fault holds until a `fault_clr_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Request master role |
| wr_i | input | 1 | Processor write strobe into transmit buffer |
| wr_data_i | input | 8 | Byte to queue |
| rd_i | input | 1 | Processor read strobe, frees receive buffer |
| rd_data_o | output | 8 | Last accepted byte |
| fault_clr_i | input | 1 | Clears the mode fault |
| cs_ni | input | 1 | Chip select from the host, active low |
| sck_i | input | 1 | Serial clock in slave role |
| sck_o | output | 1 | Serial clock in master role |
| sck_oe_o | output | 1 | Output enable for the clock pin |
| mosi_i | input | 1 | Data in for slave role |
| mosi_o | output | 1 | Data out for master role |
| mosi_oe_o | output | 1 | Output enable for the MOSI pin |
| miso_i | input | 1 | Data in for master role |
| miso_o | output | 1 | Data out for slave role |
| miso_oe_o | output | 1 | Output enable for the MISO pin |
| peer_cs_no | output | 1 | Chip select driven to a peer, active low |
| irq_no | output | 1 | Low while a queued byte awaits transfer |
| busy_no | output | 1 | Low while the receive buffer is full |
| overrun_o | output | 1 | A byte was discarded because the buffer was full |
| mode_fault_o | output | 1 | Another master selected the port in master role |
| master_o | output | 1 | Current role is master |

## Verification
A bit counter left in the wrong state shifts the byte boundary. This shows on the very next transfer as a wrong `rd_data_o` byte, or as `busy_no` falling early or not at all. A corrupt buffer flag shows on `irq_no` or `busy_no` within a few clocks of the byte that should have moved it, long before any later data. A role or fault latch that is wrong shows at once on the output enables and on `peer_cs_no`.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_MOSI = 2;
  localparam int unsigned PIN_MISO = 3;
  localparam int unsigned PIN_CNT  = 4;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned W        = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic sck_o,
  output logic busy_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DCW   = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned HALVES = 2 * W;
  localparam int unsigned HCW   = $clog2(HALVES);

  logic [DCW-1:0] div_q;
  logic [HCW-1:0] half_q;
  logic           sck_q, busy_q, tick;

  assign tick = busy_q && (div_q == DCW'(HALF_DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; half_q <= '0; sck_q <= 1'b0; busy_q <= 1'b0;
    end else if (abort_i) begin
      div_q <= '0; half_q <= '0; sck_q <= 1'b0; busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      div_q <= '0; half_q <= '0; sck_q <= 1'b0; busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (half_q == HCW'(HALVES-1)) begin
          half_q <= '0;
          busy_q <= 1'b0;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign busy_o = busy_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;

  assert_sck_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  assert_sck_level_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick && !abort_i) |=> $stable(sck_q));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         clr_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         din_i,
  input  logic [W-1:0] load_data_i,
  input  logic         load_valid_i,
  output logic         dout_o,
  output logic [W-1:0] byte_o,
  output logic         byte_done_o,
  output logic         tx_done_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  tx_sr_q, rx_sr_q;
  logic [CW-1:0] cnt_q;
  logic          owned_q, last_bit;

  assign last_bit = (cnt_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0; rx_sr_q <= '0; cnt_q <= '0; owned_q <= 1'b0;
    end else if (!active_i || clr_i) begin
      // idle: keep the outgoing byte primed, drop any partial input
      cnt_q   <= '0;
      tx_sr_q <= load_data_i;
      owned_q <= load_valid_i;
    end else begin
      if (sample_i) begin
        rx_sr_q <= {rx_sr_q[W-2:0], din_i};
        cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
      end
      if (shift_i) begin
        if (cnt_q == '0) begin
          tx_sr_q <= load_data_i;
          owned_q <= load_valid_i;
        end else begin
          tx_sr_q <= {tx_sr_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign dout_o      = tx_sr_q[W-1];
  assign byte_o      = {rx_sr_q[W-2:0], din_i};
  assign byte_done_o = active_i && !clr_i && sample_i && last_bit;
  assign tx_done_o   = byte_done_o && owned_q;

  assert_no_dual_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && shift_i));
endmodule

// File: rtl/spi_msg_buffers.sv
module spi_msg_buffers #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  input  logic         byte_done_i,
  input  logic [W-1:0] byte_i,
  input  logic         tx_done_i,
  output logic [W-1:0] load_data_o,
  output logic         tx_full_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_full_o,
  output logic         overrun_o
);
  logic [W-1:0] tx_data_q, rx_data_q;
  logic         tx_full_q, rx_full_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_q <= '0; tx_full_q <= 1'b0;
    end else begin
      if (tx_done_i) tx_full_q <= 1'b0;
      if (wr_i && !tx_full_q) begin
        tx_data_q <= wr_data_i;
        tx_full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0; rx_full_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (rd_i) ovr_q <= 1'b0;
      if (byte_done_i) begin
        if (!rx_full_q || rd_i) begin
          rx_data_q <= byte_i;
          rx_full_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end else if (rd_i) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign load_data_o = tx_full_q ? tx_data_q : '0;
  assign tx_full_o   = tx_full_q;
  assign rx_data_o   = rx_data_q;
  assign rx_full_o   = rx_full_q;
  assign overrun_o   = ovr_q;

  assert_rx_set_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(byte_done_i));
  assert_rd_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !byte_done_i) |=> !rx_full_q);
  assert_overrun_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(byte_done_i && rx_full_q));
  assert_keep_on_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && rx_full_q && !rd_i) |=> $stable(rx_data_q));
  assert_wr_full_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_full_q) |=> $stable(tx_data_q));
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              fault_clr_i,
  input  logic              cs_ni,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              peer_cs_no,
  output logic              irq_no,
  output logic              busy_no,
  output logic              overrun_o,
  output logic              mode_fault_o,
  output logic              master_o
);
  localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_CS;

  logic [PIN_CNT-1:0] pin_raw, pin_s;
  logic cs_s, sck_s, mosi_s, miso_s, sck_d_q;
  logic s_rise, s_fall, m_rise, m_fall, m_busy, m_sck;
  logic fault_q, fault_evt, start;
  role_e role;
  logic active, sample, shift, din, dout;
  logic [DATA_W-1:0] load_data, rx_byte;
  logic tx_full, rx_full, byte_done, tx_done;

  assign pin_raw[PIN_CS]   = cs_ni;
  assign pin_raw[PIN_SCK]  = sck_i;
  assign pin_raw[PIN_MOSI] = mosi_i;
  assign pin_raw[PIN_MISO] = miso_i;

  spi_pin_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_s)
  );

  assign cs_s   = pin_s[PIN_CS];
  assign sck_s  = pin_s[PIN_SCK];
  assign mosi_s = pin_s[PIN_MOSI];
  assign miso_s = pin_s[PIN_MISO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;
  end
  assign s_rise = sck_s && !sck_d_q;
  assign s_fall = !sck_s && sck_d_q;

  assign role      = (master_en_i && !fault_q) ? ROLE_MASTER : ROLE_SLAVE;
  assign fault_evt = (role == ROLE_MASTER) && !cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fault_q <= 1'b0;
    else if (fault_evt)   fault_q <= 1'b1;
    else if (fault_clr_i) fault_q <= 1'b0;
  end

  assign start = (role == ROLE_MASTER) && tx_full && !m_busy && !fault_evt;

  spi_sck_gen #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_sck (
    .clk_i, .rst_ni,
    .start_i(start),
    .abort_i((role != ROLE_MASTER) || fault_evt),
    .sck_o(m_sck), .busy_o(m_busy), .rise_o(m_rise), .fall_o(m_fall)
  );

  always_comb begin
    if (role == ROLE_MASTER) begin
      active = m_busy; sample = m_rise; shift = m_fall; din = miso_s;
    end else begin
      active = !cs_s;  sample = s_rise; shift = s_fall; din = mosi_s;
    end
  end

  spi_shift_engine #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .active_i(active), .clr_i(fault_evt),
    .sample_i(sample), .shift_i(shift), .din_i(din),
    .load_data_i(load_data), .load_valid_i(tx_full),
    .dout_o(dout), .byte_o(rx_byte),
    .byte_done_o(byte_done), .tx_done_o(tx_done)
  );

  spi_msg_buffers #(.W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i, .wr_data_i, .rd_i,
    .byte_done_i(byte_done), .byte_i(rx_byte), .tx_done_i(tx_done),
    .load_data_o(load_data), .tx_full_o(tx_full),
    .rx_data_o(rd_data_o), .rx_full_o(rx_full), .overrun_o(overrun_o)
  );

  assign sck_o        = m_sck;
  assign sck_oe_o     = (role == ROLE_MASTER);
  assign mosi_o       = dout;
  assign mosi_oe_o    = (role == ROLE_MASTER);
  assign miso_o       = dout;
  assign miso_oe_o    = (role == ROLE_SLAVE) && !cs_s;
  assign peer_cs_no   = !m_busy;
  assign irq_no       = !tx_full;
  assign busy_no      = !rx_full;
  assign mode_fault_o = fault_q;
  assign master_o     = (role == ROLE_MASTER);

  assert_oe_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miso_oe_o && (sck_oe_o || mosi_oe_o)));
  assert_peer_cs_role_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peer_cs_no |-> sck_oe_o);
  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !fault_clr_i) |=> fault_q);
  assert_fault_needs_master_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(master_en_i));
endmodule

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int HALF_DIV   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master_en = 0, wr = 0, rd = 0, fault_clr = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic cs_ni = 1, sck_i = 0, mosi_i = 0, miso_i = 0;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;
  logic peer_cs_no, irq_no, busy_no, overrun_o, mode_fault_o, master_o;

  int n_vec = 0, n_bad = 0, sck_pulses = 0;
  logic [7:0] exp_q[$];
  logic seen = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctrl_port #(.DATA_W(8), .HALF_DIV(HALF_DIV), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_en_i(master_en),
    .wr_i(wr), .wr_data_i(wr_data), .rd_i(rd), .rd_data_o(rd_data),
    .fault_clr_i(fault_clr), .cs_ni(cs_ni),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .peer_cs_no(peer_cs_no), .irq_no(irq_no), .busy_no(busy_no),
    .overrun_o(overrun_o), .mode_fault_o(mode_fault_o), .master_o(master_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: each newly filled receive buffer is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !busy_no && !seen) begin
      seen = 1;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: got %0h expected nothing", rd_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL R2: got %0h expected %0h", rd_data, e);
        end
      end
    end else if (busy_no) begin
      seen = 0;
    end
  end

  always @(posedge sck_o) sck_pulses++;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic proc_write(input logic [7:0] b);
    wr_data = b; wr = 1; idle(1); wr = 0; idle(1);
  endtask

  task automatic proc_read();
    rd = 1; idle(1); rd = 0; idle(1);
  endtask

  task automatic host_xfer(input logic [7:0] mo, input int nb, output logic [7:0] mi);
    mi = '0;
    cs_ni = 0; idle(HALF);
    for (int i = 0; i < nb; i++) begin
      mosi_i = mo[7-i];
      idle(HALF);
      if (i == 0) chk("R8 miso_oe selected", miso_oe_o, 1);
      mi = {mi[6:0], miso_o};
      sck_i = 1; idle(HALF);
      sck_i = 0;
    end
    idle(HALF); cs_ni = 1; idle(2*HALF);
  endtask

  task automatic peer_xfer(input logic [7:0] peer_b, output logic [7:0] got);
    got = '0;
    wait (peer_cs_no == 1'b0);
    miso_i = peer_b[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      got = {got[6:0], mosi_o};
      @(negedge sck_o);
      if (i < 7) miso_i = peer_b[6-i];
    end
    wait (peer_cs_no == 1'b1);
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    idle(3); rst_n = 1; idle(3);
    // R1 reset state
    chk("R1 irq_no", irq_no, 1);
    chk("R1 busy_no", busy_no, 1);
    chk("R1 peer_cs_no", peer_cs_no, 1);
    chk("R1 mode_fault", mode_fault_o, 0);
    chk("R1 overrun", overrun_o, 0);
    chk("R1 oe", {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);

    // R2 slave receive, R6 empty queue sends 0x00, R3 read frees buffer
    exp_q.push_back(8'hA5);
    host_xfer(8'hA5, 8, mi);
    chk("R2 busy_no low", busy_no, 0);
    chk("R6 empty sends zero", mi, 8'h00);
    chk("R8 slave sck/mosi oe", {sck_oe_o, mosi_oe_o}, 0);
    chk("R8 miso_oe deselected", miso_oe_o, 0);
    proc_read();
    chk("R3 busy_no released", busy_no, 1);

    // R5 queue + ignored write, R6 slave transmit
    proc_write(8'hC3);
    chk("R5 irq_no low", irq_no, 0);
    proc_write(8'h3C);
    chk("R5 still queued", irq_no, 0);
    exp_q.push_back(8'h11);
    host_xfer(8'h11, 8, mi);
    chk("R6 miso byte (R5 second write ignored)", mi, 8'hC3);
    chk("R6 irq_no released", irq_no, 1);
    proc_read();

    // R4 overrun
    exp_q.push_back(8'h5E);
    host_xfer(8'h5E, 8, mi);
    host_xfer(8'h77, 8, mi);
    chk("R4 overrun set", overrun_o, 1);
    chk("R4 first byte kept", rd_data, 8'h5E);
    chk("R4 still full", busy_no, 0);
    proc_read();
    chk("R4 overrun cleared", overrun_o, 0);
    chk("R3 busy_no after overrun read", busy_no, 1);

    // R7 partial byte dropped
    host_xfer(8'hF0, 4, mi);
    chk("R7 partial not delivered", busy_no, 1);
    exp_q.push_back(8'h96);
    host_xfer(8'h96, 8, mi);
    chk("R7 next byte delivered", busy_no, 0);
    chk("R7 next byte value", rd_data, 8'h96);
    proc_read();

    // R9 master transfer
    master_en = 1; idle(4);
    chk("R8 master oe", {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b110);
    chk("R9 peer_cs idle", peer_cs_no, 1);
    sck_pulses = 0;
    exp_q.push_back(8'h3A);
    fork
      proc_write(8'hE7);
      peer_xfer(8'h3A, mi);
    join
    chk("R9 mosi byte", mi, 8'hE7);
    chk("R9 pulse count", sck_pulses, 8);
    chk("R9 irq_no released", irq_no, 1);
    chk("R9 rx full", busy_no, 0);
    chk("R9 sck idle low", sck_o, 0);
    proc_read();

    // R10 mode fault
    cs_ni = 0; idle(6);
    chk("R10 fault set", mode_fault_o, 1);
    chk("R10 forced slave", {sck_oe_o, master_o, peer_cs_no}, 3'b001);
    cs_ni = 1; idle(6);
    chk("R10 fault held", mode_fault_o, 1);
    fault_clr = 1; idle(1); fault_clr = 0; idle(2);
    chk("R10 fault cleared", mode_fault_o, 0);
    chk("R10 master restored", sck_oe_o, 1);
    master_en = 0; idle(4);

    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule